// File: doc/BRIEF.md
# Paged SRAM Window Decoder

This block sits between a host bus and a battery-backed memory card. It watches every host memory cycle. When the card is switched in, a cycle that falls in the 8 KB region at 0x4000 is steered to one of two places. The lower 6 KB (0x4000-0x57FF) goes to a firmware SRAM. The upper 2 KB (0x5800-0x5FFF) is a window onto a bank of up to 32 paged data SRAMs.

The page shown in the window is set by sixteen control flags held elsewhere. Flag 0 switches the card in. The page bits are spread over the upper SRAM address pins, a 1-of-16 chip select and a 1-of-4 group select. How they are spread depends on the size of the fitted chips: 32K, 128K or 512K parts. Host address bits 10..0 form the 2 KB offset inside a page and go straight to the chips, so they do not pass through this block.

Every output is registered. A card-disable switch silences the whole card. A main-power-good input turns off all data-chip selects while the supply is down.

Top module: `paged_sram_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, every chip select, `dbuf_en_n` and `bp_req_n` go high (inactive) and `sram_hi` goes to zero, whatever the other inputs are.
- R2: All outputs are registered. They reflect the inputs sampled at the previous rising clock edge and do not change between edges.
- R3: A cycle with `mem_en_n`=0, `card_off`=0, flag 0 = 1 and an address in 0x4000-0x57FF drives `fw_cs_n` low. Here the address top three bits are 010 and bits 12:11 are not 11.
- R4: The same conditions with an address in 0x5800-0x5FFF drive low the single `data_cs_n` bit given by the chip index, provided `pwr_good`=1.
- R5: There is no response in three cases: `mem_en_n` is high, flag 0 is clear, or the address is outside 0x4000-0x5FFF. No response means every select, `dbuf_en_n` and `bp_req_n` stay high.
- R6: `card_off`=1 blocks every response in the same way as R5.
- R7: When `pwr_good`=0, all `data_cs_n` bits stay high. Firmware selection and the two buffer enables are unaffected.
- R8: `chip_size`=0 (32K parts). This is also used for the reserved code 3. `sram_hi` bits 0..3 (SRAM A11..A14) take flags 2,1,4,3. Bits 4..7 are zero. The chip select bits 0..3 take flags 5..8. Group bit 0 takes flag 10 and group bit 1 takes flag 9.
- R9: `chip_size`=1 (128K parts). `sram_hi` bits 0..5 (A11..A16) take flags 2,1,3,4,6,5. Bits 6..7 are zero. The select bits 0..3 take flags 7..10. Group bit 0 takes flag 11 and group bit 1 is zero.
- R10: `chip_size`=2 (512K parts). `sram_hi` bits 0..7 (A11..A18) take flags 2,1,3,4,6,5,7,13. The select bits 0..3 take flags 8..11. Group bit 0 takes flag 12 and group bit 1 is zero.
- R11: The chip index is group*16 + select. An index of `N_CHIPS` (32) or more selects no data chip.
- R12: Any cycle that selects a window, firmware or data, drives both `dbuf_en_n` and `bp_req_n` low. A data-window cycle does this even when the chip select is suppressed by R7 or R11.
- R13: At most one of `fw_cs_n` and the `data_cs_n` bits is low in any cycle.
- R14: `sram_hi` follows the flag routing of R8-R10 on every cycle, access or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 16 | Host address, bit 15 most significant |
| mem_en_n | input | 1 | Memory cycle strobe, active low |
| ctrl_flags | input | 16 | Control flags; bit 0 switches the card in, bits 1..13 carry the page |
| chip_size | input | 2 | Fitted part: 0 = 32K, 1 = 128K, 2 = 512K, 3 = treated as 32K |
| card_off | input | 1 | Card-disable switch, active high |
| pwr_good | input | 1 | Main supply present |
| fw_cs_n | output | 1 | Firmware SRAM select, active low |
| data_cs_n | output | 32 | One-hot-low data SRAM selects |
| sram_hi | output | 8 | Upper SRAM address bits A11..A18 (bit 0 = A11) |
| dbuf_en_n | output | 1 | Local data-bus buffer enable, active low |
| bp_req_n | output | 1 | Backplane read-buffer request, active low |

## Verification
Each output is due exactly one rising edge after the inputs that cause it. The bench drives a new input set on a falling edge and compares every output on the next falling edge. The first case is a directed one. It probes the outputs a quarter period after a new stimulus is applied, before the edge, to show that nothing has moved early. Expected values come from bench functions that apply the routing tables, the window rules, and the power and switch overrides to the same inputs.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int HI_W  = 8;   // SRAM A11..A18
  localparam int SEL_W = 4;   // 1-of-16 chip select inputs
  localparam int GRP_W = 2;   // 1-of-4 group select inputs

  typedef enum logic [1:0] {
    SZ_32K  = 2'd0,
    SZ_128K = 2'd1,
    SZ_512K = 2'd2,
    SZ_RSVD = 2'd3
  } chip_size_e;

  typedef struct packed {
    logic [HI_W-1:0]  hi;
    logic [GRP_W-1:0] grp;
    logic [SEL_W-1:0] sel;
  } page_route_t;
endpackage

// File: rtl/psd_window_decode.sv
module psd_window_decode #(
  parameter int ADDR_W     = 16,
  parameter int REGION_W   = 3,
  parameter int WIN_REGION = 2,
  parameter int SUB_W      = 2,
  parameter int DATA_SUB   = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_en_n,
  input  logic              card_off,
  input  logic              card_en,
  output logic              fw_hit,
  output logic              data_hit
);
  localparam int SUB_TOP = ADDR_W - REGION_W - 1;

  logic [REGION_W-1:0] region;
  logic [SUB_W-1:0]    sub;
  logic                live;
  logic                unused_addr_lo;

  assign region = addr[ADDR_W-1 -: REGION_W];
  assign sub    = addr[SUB_TOP -: SUB_W];
  assign unused_addr_lo = ^addr[SUB_TOP-SUB_W:0];

  assign live     = !mem_en_n && !card_off && card_en &&
                    (region == REGION_W'(WIN_REGION));
  assign fw_hit   = live && (sub != SUB_W'(DATA_SUB));
  assign data_hit = live && (sub == SUB_W'(DATA_SUB));
endmodule

// File: rtl/psd_page_route.sv
module psd_page_route
  import psd_pkg::*;
#(
  parameter int FLAG_W = 16
) (
  input  logic [FLAG_W-1:0] flags,
  input  logic [1:0]        chip_size,
  output page_route_t       route
);
  logic [FLAG_W-1:0] f;
  logic              unused_flags;

  assign f = flags;
  assign unused_flags = ^{f[FLAG_W-1:14], f[0]};

  always_comb begin
    route = '0;
    // page bits below A13 are wired the same for every part size
    route.hi[0] = f[2];
    route.hi[1] = f[1];
    unique case (chip_size_e'(chip_size))
      SZ_128K: begin
        route.hi[2] = f[3];
        route.hi[3] = f[4];
        route.hi[4] = f[6];
        route.hi[5] = f[5];
        route.sel   = {f[10], f[9], f[8], f[7]};
        route.grp   = {1'b0, f[11]};
      end
      SZ_512K: begin
        route.hi[2] = f[3];
        route.hi[3] = f[4];
        route.hi[4] = f[6];
        route.hi[5] = f[5];
        route.hi[6] = f[7];
        route.hi[7] = f[13];
        route.sel   = {f[11], f[10], f[9], f[8]};
        route.grp   = {1'b0, f[12]};
      end
      default: begin  // 32K parts and the reserved code
        route.hi[2] = f[4];
        route.hi[3] = f[3];
        route.sel   = {f[8], f[7], f[6], f[5]};
        route.grp   = {f[9], f[10]};
      end
    endcase
  end
endmodule

// File: rtl/psd_chip_select.sv
module psd_chip_select #(
  parameter int N_CHIPS = 32,
  parameter int SEL_W   = 4,
  parameter int GRP_W   = 2
) (
  input  logic               en,
  input  logic [SEL_W-1:0]   sel,
  input  logic [GRP_W-1:0]   grp,
  output logic [N_CHIPS-1:0] cs_n
);
  localparam int IDX_W = SEL_W + GRP_W;

  logic [IDX_W-1:0] idx;
  assign idx = {grp, sel};

  for (genvar i = 0; i < N_CHIPS; i++) begin : g_cs
    assign cs_n[i] = ~(en && (idx == IDX_W'(i)));
  end

  // R11: an index past the fitted bank drives no select
  always_comb begin
    if (int'(idx) >= N_CHIPS)
      a_r11_no_chip_past_bank : assert (&cs_n);
  end
endmodule

// File: rtl/paged_sram_decoder.sv
module paged_sram_decoder
  import psd_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int FLAG_W  = 16,
  parameter int N_CHIPS = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic               mem_en_n,
  input  logic [FLAG_W-1:0]  ctrl_flags,
  input  logic [1:0]         chip_size,
  input  logic               card_off,
  input  logic               pwr_good,
  output logic               fw_cs_n,
  output logic [N_CHIPS-1:0] data_cs_n,
  output logic [HI_W-1:0]    sram_hi,
  output logic               dbuf_en_n,
  output logic               bp_req_n
);
  logic               fw_hit, data_hit;
  page_route_t        route;
  logic [N_CHIPS-1:0] cs_n_d;
  logic               any_hit;

  psd_window_decode #(.ADDR_W(ADDR_W)) u_win (
    .addr     (host_addr),
    .mem_en_n (mem_en_n),
    .card_off (card_off),
    .card_en  (ctrl_flags[0]),
    .fw_hit   (fw_hit),
    .data_hit (data_hit)
  );

  psd_page_route #(.FLAG_W(FLAG_W)) u_route (
    .flags     (ctrl_flags),
    .chip_size (chip_size),
    .route     (route)
  );

  psd_chip_select #(.N_CHIPS(N_CHIPS), .SEL_W(SEL_W), .GRP_W(GRP_W)) u_cs (
    .en   (data_hit && pwr_good),
    .sel  (route.sel),
    .grp  (route.grp),
    .cs_n (cs_n_d)
  );

  assign any_hit = fw_hit || data_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      fw_cs_n   <= 1'b1;
      data_cs_n <= '1;
      sram_hi   <= '0;
      dbuf_en_n <= 1'b1;
      bp_req_n  <= 1'b1;
    end else begin
      fw_cs_n   <= ~fw_hit;
      data_cs_n <= cs_n_d;
      sram_hi   <= route.hi;
      dbuf_en_n <= ~any_hit;
      bp_req_n  <= ~any_hit;
    end
  end

  // R13: never two selects at once
  a_r13_single_select : assert property (@(posedge clk) disable iff (rst)
    $countones({~data_cs_n, ~fw_cs_n}) <= 1);

  // R5: no memory cycle, no response
  a_r5_idle_quiet : assert property (@(posedge clk) disable iff (rst)
    mem_en_n |=> (fw_cs_n && (&data_cs_n) && dbuf_en_n && bp_req_n));

  // R6: disable switch silences the card
  a_r6_switch_off : assert property (@(posedge clk) disable iff (rst)
    card_off |=> (fw_cs_n && (&data_cs_n) && dbuf_en_n && bp_req_n));

  // R7: power loss keeps data chips deselected
  a_r7_power_loss : assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> (&data_cs_n));

  // R12: any select comes with both buffer enables
  a_r12_buffers_follow : assert property (@(posedge clk) disable iff (rst)
    (!fw_cs_n || !(&data_cs_n)) |-> (!dbuf_en_n && !bp_req_n));
endmodule

// File: tb/paged_sram_decoder_bench.sv
module paged_sram_decoder_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] host_addr;
  logic        mem_en_n;
  logic [15:0] ctrl_flags;
  logic [1:0]  chip_size;
  logic        card_off;
  logic        pwr_good;
  logic        fw_cs_n;
  logic [31:0] data_cs_n;
  logic [7:0]  sram_hi;
  logic        dbuf_en_n;
  logic        bp_req_n;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  paged_sram_decoder u_paged_sram_decoder (
    .clk(clk), .rst(rst), .host_addr(host_addr), .mem_en_n(mem_en_n),
    .ctrl_flags(ctrl_flags), .chip_size(chip_size), .card_off(card_off),
    .pwr_good(pwr_good), .fw_cs_n(fw_cs_n), .data_cs_n(data_cs_n),
    .sram_hi(sram_hi), .dbuf_en_n(dbuf_en_n), .bp_req_n(bp_req_n)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // routing tables of R8, R9, R10 (code 3 behaves as 32K)
  function automatic logic [7:0] ref_hi(logic [15:0] f, logic [1:0] sz);
    case (sz)
      2'd1:    return {2'b00, f[5], f[6], f[4], f[3], f[1], f[2]};
      2'd2:    return {f[13], f[7], f[5], f[6], f[4], f[3], f[1], f[2]};
      default: return {4'b0000, f[3], f[4], f[1], f[2]};
    endcase
  endfunction

  function automatic int ref_idx(logic [15:0] f, logic [1:0] sz);
    case (sz)
      2'd1:    return 16 * int'(f[11]) + int'({f[10], f[9], f[8], f[7]});
      2'd2:    return 16 * int'(f[12]) + int'({f[11], f[10], f[9], f[8]});
      default: return 16 * int'({f[9], f[10]}) + int'({f[8], f[7], f[6], f[5]});
    endcase
  endfunction

  // drive at a falling edge, compare at the next falling edge
  task automatic step(logic [15:0] a, logic men, logic [15:0] f,
                      logic [1:0] sz, logic off, logic pg, string tag);
    logic        live, fw, dat;
    logic [31:0] exp_cs;
    int          idx;
    host_addr = a; mem_en_n = men; ctrl_flags = f;
    chip_size = sz; card_off = off; pwr_good = pg;
    live = !men && !off && f[0] && (a[15:13] == 3'b010);
    fw   = live && (a[12:11] != 2'b11);
    dat  = live && (a[12:11] == 2'b11);
    idx  = ref_idx(f, sz);
    exp_cs = '1;
    if (dat && pg && idx < 32) exp_cs[idx] = 1'b0;
    @(negedge clk);
    check({tag, " R3 fw_cs_n"},   64'(fw_cs_n),   64'(!fw));
    check({tag, " R4 R11 data_cs_n"}, 64'(data_cs_n), 64'(exp_cs));
    check({tag, " R14 sram_hi"},  64'(sram_hi),   64'(ref_hi(f, sz)));
    check({tag, " R12 dbuf_en_n"}, 64'(dbuf_en_n), 64'(!(fw || dat)));
    check({tag, " R12 bp_req_n"},  64'(bp_req_n),  64'(!(fw || dat)));
  endtask

  initial begin
    #4_000_000;
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [15:0] fl;
    // R1: reset overrides a live firmware access
    rst = 1'b1; host_addr = 16'h4000; mem_en_n = 1'b0; ctrl_flags = 16'hFFFF;
    chip_size = 2'd2; card_off = 1'b0; pwr_good = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 fw_cs_n", 64'(fw_cs_n), 64'd1);
    check("R1 data_cs_n", 64'(data_cs_n), 64'hFFFF_FFFF);
    check("R1 sram_hi", 64'(sram_hi), 64'd0);
    check("R1 buffers", 64'({dbuf_en_n, bp_req_n}), 64'd3);
    rst = 1'b0;
    mem_en_n = 1'b1;
    @(negedge clk);

    // R2: new access must not show before the next rising edge
    host_addr = 16'h4123; mem_en_n = 1'b0; ctrl_flags = 16'h0001; chip_size = 2'd0;
    #5;
    check("R2 no early fw_cs_n", 64'(fw_cs_n), 64'd1);
    @(negedge clk);
    check("R2 R3 fw_cs_n after edge", 64'(fw_cs_n), 64'd0);

    // R3 top of the firmware window, R4 window edges
    step(16'h57FF, 1'b0, 16'h0001, 2'd0, 1'b0, 1'b1, "R3 fw top");
    step(16'h5800, 1'b0, 16'h0001, 2'd0, 1'b0, 1'b1, "R4 chip0");
    // R8: 32K index 31 = grp1 (flag10) sel 15 (flags 5..8)
    step(16'h5FFF, 1'b0, 16'h05E1, 2'd0, 1'b0, 1'b1, "R8 chip31");
    // R11: flag 9 sets group bit 1 for 32K -> index >= 32
    step(16'h5800, 1'b0, 16'h0201, 2'd0, 1'b0, 1'b1, "R11 past bank");
    step(16'h5800, 1'b0, 16'h0201, 2'd3, 1'b0, 1'b1, "R8 reserved code");
    // R9, R10 directed routings
    step(16'h5A00, 1'b0, 16'h0FFF, 2'd1, 1'b0, 1'b1, "R9 all ones");
    step(16'h5A00, 1'b0, 16'h2055, 2'd2, 1'b0, 1'b1, "R10 mixed");
    // R5: outside window, strobe high, flag 0 clear
    step(16'h6000, 1'b0, 16'h0001, 2'd0, 1'b0, 1'b1, "R5 outside");
    step(16'h3FFF, 1'b0, 16'h0001, 2'd0, 1'b0, 1'b1, "R5 below");
    step(16'h4000, 1'b1, 16'h0001, 2'd0, 1'b0, 1'b1, "R5 no strobe");
    step(16'h5800, 1'b0, 16'h0000, 2'd0, 1'b0, 1'b1, "R5 flag0 clear");
    // R6 switch, R7 power
    step(16'h4000, 1'b0, 16'h0001, 2'd0, 1'b1, 1'b1, "R6 switch fw");
    step(16'h5800, 1'b0, 16'h0001, 2'd0, 1'b1, 1'b1, "R6 switch data");
    step(16'h5800, 1'b0, 16'h0001, 2'd0, 1'b0, 1'b0, "R7 power data");
    step(16'h4800, 1'b0, 16'h0001, 2'd0, 1'b0, 1'b0, "R7 power fw");

    // constrained random mix, fixed seed; R13 checked each step
    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      a  = ($urandom_range(0, 1) == 0) ? (16'h4000 | 16'($urandom_range(0, 16'h1FFF)))
                                       : 16'($urandom);
      fl = 16'($urandom);
      fl[0] = ($urandom_range(0, 9) != 0);
      step(a, ($urandom_range(0, 6) == 0), fl, 2'($urandom_range(0, 3)),
           ($urandom_range(0, 9) == 0), ($urandom_range(0, 6) != 0), "rand");
      check("R13 single select", 64'($countones({~data_cs_n, ~fw_cs_n}) <= 1), 64'd1);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule